// File: doc/BRIEF.md
# I2C Master Register and Interrupt Front-End

This block sits between a processor register bus and a command-driven I2C bus engine. Software queues 10-bit commands into a transmit FIFO. Each command is a data byte plus start and stop flags. Received bytes come back through a separate receive FIFO. One bus address serves both FIFOs: a write goes to the transmit queue and a read takes from the receive queue.

The block also holds the following:
- A status word. It combines sticky event flags, the live engine conditions and the FIFO full and empty states.
- A control word. It carries the per-event interrupt enables and a soft reset that clears itself.
- Two SCL divider registers.
- Readback of both FIFO fill levels.
- Counters of bytes moved in each direction.

The enabled events are merged into a single registered interrupt line.

The bus is a single-cycle register port. A write completes on the clock edge that samples `wr_en`. Read data is registered and appears on `rdata` one clock after `rd_en`. A read of the receive FIFO removes its head entry on that same edge.

Top module: `i2cfe_regs`

## Requirements
- R1: After reset the following hold: both dividers read 0x3FF, control reads 0, the status word reads 0xA00 (receive-empty bit 9 and transmit-empty bit 11 set) when all engine inputs are low, and `irq` is low.
- R2: Writes to offset 0x00 queue the low 10 bits of the write data. The engine sees the entries on `tx_cmd` in write order, and each `tx_pop` advances to the next entry.
- R3: Bytes pushed by the engine are returned in push order by reads of offset 0x00. A read while the receive FIFO is empty returns 0.
- R4: A push into a full FIFO of DEPTH entries is dropped and leaves the contents unchanged. Status bit 10 shows transmit full and bit 8 shows receive full.
- R5: Offset 0x18 reads the receive FIFO level and offset 0x1C reads the transmit FIFO level.
- R6: Status bit 0 (done) and bit 1 (arbitration loss) are set by engine pulses. Writing 1 to either bit at offset 0x04 clears that flag, and writing 0 leaves it unchanged.
- R7: The following status bits follow the engine inputs live: bit 2 no-acknowledge, bit 3 data request, bit 5 bus active, bit 6 SCL and bit 7 SDA.
- R8: Control bits 0 to 7 enable these conditions as interrupt sources, in order: done, arbitration loss, no-acknowledge, data request, slave data request, receive full, receive not empty, transmit full. `irq` is the registered OR of each enabled condition and rises one clock after an enabled condition is true.
- R9: Writing 1 to control bit 8 starts a soft reset that lasts RST_CYCLES clocks. During that time the following hold:
  - bit 8 reads 1 and `eng_abort` is high;
  - both FIFOs are held empty;
  - both byte counters are held at 0.
  
  Bit 8 then reads 0. The interrupt enables are kept.
- R10: The SCL low divider at 0x0C and the SCL high divider at 0x10 keep only the low 10 bits of a write. They drive `div_lo` and `div_hi`.
- R11: Offset 0x20 counts the bytes accepted into the receive FIFO and offset 0x24 counts the commands the engine has taken from the transmit FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| tx_cmd | output | 10 | Head transmit command |
| tx_avail | output | 1 | Transmit FIFO not empty |
| tx_pop | input | 1 | Engine takes head command |
| rx_byte | input | 8 | Byte from engine |
| rx_push | input | 1 | Engine delivers byte |
| done_set | input | 1 | Transaction finished pulse |
| arb_set | input | 1 | Arbitration lost pulse |
| eng_nack | input | 1 | No-acknowledge condition |
| eng_drq | input | 1 | Engine needs data |
| eng_sdrq | input | 1 | Slave data request |
| eng_active | input | 1 | Bus active |
| scl_in | input | 1 | Live SCL level |
| sda_in | input | 1 | Live SDA level |
| eng_abort | output | 1 | Engine abort during soft reset |
| div_lo | output | 10 | SCL low divider |
| div_hi | output | 10 | SCL high divider |

## Verification
The bench uses the default parameters: DEPTH of 4, a 10-bit command width, an 8-bit receive width and RST_CYCLES of 4. A depth of 4 lets a few bus writes or engine pushes reach the full flags and the dropped-push case. A short reset window lets the bench read control bit 8 both while the soft reset is running and after it ends. The 10-bit divider width lets one write carry set bits above bit 9, which shows that they are truncated.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  localparam logic [5:0] OFF_FIFO   = 6'h00;
  localparam logic [5:0] OFF_STAT   = 6'h04;
  localparam logic [5:0] OFF_CTRL   = 6'h08;
  localparam logic [5:0] OFF_DIVLO  = 6'h0C;
  localparam logic [5:0] OFF_DIVHI  = 6'h10;
  localparam logic [5:0] OFF_RXLVL  = 6'h18;
  localparam logic [5:0] OFF_TXLVL  = 6'h1C;
  localparam logic [5:0] OFF_RXCNT  = 6'h20;
  localparam logic [5:0] OFF_TXCNT  = 6'h24;
  localparam int SOFT_RST_BIT = 8;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      level <= level + LW'(do_push) - LW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R4
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> (level == LW'(DEPTH))); // R4
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    empty |-> (head == '0)); // R3
endmodule

// File: rtl/i2cfe_rst_seq.sv
module i2cfe_rst_seq #(
  parameter int RST_CYCLES = 4,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;
  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (start && !busy) cnt <= CW'(RST_CYCLES);
    else if (busy)          cnt <= cnt - 1'b1;
  end

  AST_RST_STARTS: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R9
endmodule

// File: rtl/i2cfe_regs.sv
module i2cfe_regs
  import i2cfe_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int TXW        = 10,
  parameter int RXW        = 8,
  parameter int DIV_W      = 10,
  parameter int CNT_W      = 16,
  parameter int RST_CYCLES = 4,
  parameter logic [DIV_W-1:0] DIV_INIT = '1,
  localparam int LW        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             irq,
  output logic [TXW-1:0]   tx_cmd,
  output logic             tx_avail,
  input  logic             tx_pop,
  input  logic [RXW-1:0]   rx_byte,
  input  logic             rx_push,
  input  logic             done_set,
  input  logic             arb_set,
  input  logic             eng_nack,
  input  logic             eng_drq,
  input  logic             eng_sdrq,
  input  logic             eng_active,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             eng_abort,
  output logic [DIV_W-1:0] div_lo,
  output logic [DIV_W-1:0] div_hi
);
  logic [7:0]     ien;
  logic           done_f, arb_f;
  logic           busy;
  logic [LW-1:0]  tx_lvl, rx_lvl;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic [RXW-1:0] rx_head;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic           wr_fifo, rd_fifo, wr_stat, wr_ctrl;
  logic [7:0]     cond;
  logic [31:0]    stat_w, rd_mux;

  assign wr_fifo = wr_en && addr == OFF_FIFO;
  assign rd_fifo = rd_en && addr == OFF_FIFO;
  assign wr_stat = wr_en && addr == OFF_STAT;
  assign wr_ctrl = wr_en && addr == OFF_CTRL;
  assign eng_abort = busy;
  assign tx_avail  = !tx_empty;

  i2cfe_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(busy), .push(wr_fifo), .din(wdata[TXW-1:0]),
    .pop(tx_pop), .head(tx_cmd), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

  i2cfe_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(busy), .push(rx_push), .din(rx_byte),
    .pop(rd_fifo), .head(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

  i2cfe_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_srst (
    .clk(clk), .rst(rst), .start(wr_ctrl && wdata[SOFT_RST_BIT]), .busy(busy));

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0; done_f <= 1'b0; arb_f <= 1'b0;
      div_lo <= DIV_INIT; div_hi <= DIV_INIT;
    end else begin
      if (wr_ctrl) ien <= wdata[7:0];
      if (wr_en && addr == OFF_DIVLO) div_lo <= wdata[DIV_W-1:0];
      if (wr_en && addr == OFF_DIVHI) div_hi <= wdata[DIV_W-1:0];
      if (done_set)                  done_f <= 1'b1;
      else if (wr_stat && wdata[0])  done_f <= 1'b0;
      if (arb_set)                   arb_f <= 1'b1;
      else if (wr_stat && wdata[1])  arb_f <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || busy) begin
      rx_cnt <= '0; tx_cnt <= '0;
    end else begin
      if (rx_push && !rx_full)  rx_cnt <= rx_cnt + 1'b1;
      if (tx_pop && !tx_empty)  tx_cnt <= tx_cnt + 1'b1;
    end
  end

  assign cond   = {tx_full, !rx_empty, rx_full, eng_sdrq, eng_drq, eng_nack, arb_f, done_f};
  assign stat_w = {20'b0, tx_empty, tx_full, rx_empty, rx_full, sda_in, scl_in,
                   eng_active, 1'b0, eng_drq, eng_nack, arb_f, done_f};

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFF_FIFO:  rd_mux = 32'(rx_head);
      OFF_STAT:  rd_mux = stat_w;
      OFF_CTRL:  rd_mux = {23'b0, busy, ien};
      OFF_DIVLO: rd_mux = 32'(div_lo);
      OFF_DIVHI: rd_mux = 32'(div_hi);
      OFF_RXLVL: rd_mux = 32'(rx_lvl);
      OFF_TXLVL: rd_mux = 32'(tx_lvl);
      OFF_RXCNT: rd_mux = 32'(rx_cnt);
      OFF_TXCNT: rd_mux = 32'(tx_cnt);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0; irq <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq <= |(ien & cond);
    end
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == 8'h00) |=> !irq); // R8
  AST_DONE_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && wdata[0] && !done_set) |=> !done_f); // R6
  AST_ARB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (arb_f && !(wr_stat && wdata[1])) |=> arb_f); // R6
  AST_RST_FLUSH: assert property (@(posedge clk) disable iff (rst)
    busy |=> (tx_lvl == '0 && rx_lvl == '0 && rx_cnt == '0)); // R9
endmodule

// File: tb/i2cfe_regs_tb.sv
module i2cfe_regs_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic [5:0] addr = '0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] wdata = '0, rdata;
  logic irq, tx_avail, tx_pop = 0, rx_push = 0, done_set = 0, arb_set = 0;
  logic eng_nack = 0, eng_drq = 0, eng_sdrq = 0, eng_active = 0, scl_in = 0, sda_in = 0;
  logic [9:0] tx_cmd, div_lo, div_hi;
  logic [7:0] rx_byte = '0;
  logic eng_abort;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  i2cfe_regs u_dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .tx_cmd(tx_cmd), .tx_avail(tx_avail),
    .tx_pop(tx_pop), .rx_byte(rx_byte), .rx_push(rx_push), .done_set(done_set),
    .arb_set(arb_set), .eng_nack(eng_nack), .eng_drq(eng_drq), .eng_sdrq(eng_sdrq),
    .eng_active(eng_active), .scl_in(scl_in), .sda_in(sda_in), .eng_abort(eng_abort),
    .div_lo(div_lo), .div_hi(div_hi));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk); rx_byte = b; rx_push = 1;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  // divider table: offset, write value, expected readback (R10)
  localparam logic [5:0]  VA [4] = '{6'h0C, 6'h10, 6'h0C, 6'h10};
  localparam logic [31:0] VW [4] = '{32'h0000_0062, 32'hFFFF_F401, 32'h0000_0C00, 32'h0000_03FF};
  localparam logic [31:0] VE [4] = '{32'h062, 32'h001, 32'h000, 32'h3FF};

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(6'h0C, v); chk("R1 div_lo", v, 32'h3FF);
    rd(6'h10, v); chk("R1 div_hi", v, 32'h3FF);
    rd(6'h08, v); chk("R1 ctrl", v, 32'h0);
    rd(6'h04, v); chk("R1 status", v, 32'hA00);
    chk("R1 irq", 32'(irq), 32'h0);

    for (int i = 0; i < 4; i++) begin
      wr(VA[i], VW[i]); rd(VA[i], v); chk("R10 divider", v, VE[i]);
    end
    chk("R10 div_hi port", 32'(div_hi), 32'h3FF);

    // R2 transmit order
    wr(6'h00, 32'h0000_0312); wr(6'h00, 32'h0000_0134);
    chk("R2 head0", 32'(tx_cmd), 32'h312);
    rd(6'h1C, v); chk("R5 tx level", v, 32'd2);
    pop_tx(); chk("R2 head1", 32'(tx_cmd), 32'h134);
    pop_tx(); chk("R2 avail", 32'(tx_avail), 32'h0);
    rd(6'h24, v); chk("R11 tx count", v, 32'd2);

    // R4 transmit full
    for (int i = 0; i < 5; i++) wr(6'h00, 32'(i + 1));
    rd(6'h04, v); chk("R4 tx full bit10", 32'(v[10]), 32'h1);
    rd(6'h1C, v); chk("R4 tx level capped", v, 32'd4);
    for (int i = 0; i < 4; i++) begin
      chk("R4 tx content", 32'(tx_cmd), 32'(i + 1)); pop_tx();
    end

    // R3 receive order, R4 receive full drop
    rd(6'h00, v); chk("R3 empty read", v, 32'h0);
    for (int i = 0; i < 5; i++) push_rx(8'hA0 + 8'(i));
    rd(6'h18, v); chk("R5 rx level", v, 32'd4);
    rd(6'h04, v); chk("R4 rx full bit8", 32'(v[8]), 32'h1);
    rd(6'h20, v); chk("R11 rx count", v, 32'd4);
    for (int i = 0; i < 4; i++) begin
      rd(6'h00, v); chk("R3 rx data", v, 32'hA0 + 32'(i));
    end
    rd(6'h00, v); chk("R3 empty after drain", v, 32'h0);

    // R7 live bits
    @(negedge clk); eng_nack = 1; eng_drq = 1; eng_active = 1; scl_in = 1; sda_in = 1;
    rd(6'h04, v); chk("R7 live bits", v & 32'hEC, 32'hEC);
    @(negedge clk); eng_nack = 0; eng_drq = 0; eng_active = 0; scl_in = 0; sda_in = 0;

    // R6 sticky flags and W1C
    @(negedge clk); done_set = 1; arb_set = 1;
    @(negedge clk); done_set = 0; arb_set = 0;
    wr(6'h04, 32'h0);
    rd(6'h04, v); chk("R6 write0 keeps", v & 32'h3, 32'h3);
    wr(6'h04, 32'h1);
    rd(6'h04, v); chk("R6 clear done only", v & 32'h3, 32'h2);
    wr(6'h04, 32'h2);
    rd(6'h04, v); chk("R6 clear arb", v & 32'h3, 32'h0);

    // R8 interrupt
    wr(6'h08, 32'h01);
    @(negedge clk); done_set = 1;
    @(negedge clk); done_set = 0;
    chk("R8 irq pre", 32'(irq), 32'h0);
    @(negedge clk); chk("R8 irq done", 32'(irq), 32'h1);
    wr(6'h04, 32'h1); @(negedge clk);
    chk("R8 irq cleared", 32'(irq), 32'h0);
    wr(6'h08, 32'h40); push_rx(8'h55); @(negedge clk);
    chk("R8 irq rx avail", 32'(irq), 32'h1);
    wr(6'h08, 32'h10); @(negedge clk); chk("R8 sdrq masked low", 32'(irq), 32'h0);
    @(negedge clk); eng_sdrq = 1; @(negedge clk); @(negedge clk);
    chk("R8 irq sdrq", 32'(irq), 32'h1);
    @(negedge clk); eng_sdrq = 0;

    // R9 soft reset
    wr(6'h00, 32'h11); wr(6'h00, 32'h22);
    wr(6'h08, 32'h150);
    chk("R9 abort", 32'(eng_abort), 32'h1);
    rd(6'h08, v); chk("R9 busy bit", v, 32'h150);
    repeat (6) @(negedge clk);
    rd(6'h08, v); chk("R9 self clear", v, 32'h050);
    rd(6'h1C, v); chk("R9 tx flushed", v, 32'h0);
    rd(6'h18, v); chk("R9 rx flushed", v, 32'h0);
    rd(6'h24, v); chk("R9 counter cleared", v, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule